// File: doc/BRIEF.md
# Auto-Incrementing Buffer Array Access Port

This block gives a host a narrow register window into two small on-chip buffer banks, for example a scratch buffer used for read-modify-write traffic and a buffer that collects compare results. The host sees four register slots behind a single access strobe: a control register, a 64-bit data register, a check-byte register and one unused slot. Through the control register the host picks a bank, sets a starting entry, and turns on auto-increment and the built-in check-byte generator.

A word written to the data register is only staged. It reaches the array when the check-byte register is written, which commits the staged word and its check byte to the entry under the pointer. Any access to the check-byte register, read or write, also steps the pointer when auto-increment is on. So a host streams through a bank by alternating data and check-byte accesses. Each bank has its own wrap point. Bank 0 wraps at its full physical depth. Bank 1 wraps at a smaller entry count, so its pointer returns to zero before it reaches the physical end of the storage.

The check-byte generator is a simple stand-in: each check bit is the parity of one byte of the word. Read data is registered and appears one cycle after the read strobe.

Top module: `arrport`

## Requirements
- R1: After reset the control readback is zero, the pointer is zero and every entry of both banks reads as zero data with a zero check byte.
- R2: Register slot 0 is control. A write to it sets auto-increment from bit 0, generator enable from bit 1 and bank select from bit 2, and loads the pointer at once from bits 19:16. A read of it returns those three flags in the same bits, the current pointer in bits 19:16, and zero elsewhere.
- R3: If the address written to the control register is at or above the wrap count of the selected bank, the pointer loads zero.
- R4: A write to register slot 1 (data) only stages the word and leaves the array unchanged. A write to slot 2 (check byte) stores the staged word into the selected bank at the pointer.
- R5: With the generator enabled, the stored check byte has bit i equal to the XOR of word bits 8i+7 down to 8i, and the written check value is ignored. With the generator disabled, bits 7:0 of the written value are stored.
- R6: A read of slot 1 returns the data of the entry under the pointer without moving it. A read of slot 2 returns that entry's check byte in bits 7:0 with zeros above.
- R7: With auto-increment on, every access to slot 2, read or write, advances the pointer by one after the access.
- R8: With auto-increment off, the pointer does not move on slot 2 accesses.
- R9: An advance from the last entry wraps the pointer to zero: after entry WRAP0-1 (15) for bank 0 and after entry WRAP1-1 (9) for bank 1.
- R10: Read data appears on the read-data port in the cycle after the read strobe and holds until the next read. Slot 3 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regEn | input | 1 | Register access strobe, one access per cycle |
| regWe | input | 1 | 1 for a write, 0 for a read |
| regAddr | input | 2 | Register slot: 0 control, 1 data, 2 check byte, 3 unused |
| regWdata | input | 64 | Write data |
| regRdata | output | 64 | Registered read data |

## Verification
The hardest case to reach is the wrap of bank 1 at its reduced count. The pointer has to be walked to entry 9 of that bank while auto-increment is on, and then a check-byte access has to land there; the storage behind entries 10 to 15 must never be reached. Directed sequences load the pointer close to each wrap point and then step across it with both check-byte reads and writes. Long random runs mix control reloads (including out-of-range addresses), staging writes and commits, so the pointer crosses both wrap points many times with different flag settings.

// File: rtl/arrport_pkg.sv
package arrport_pkg;

  localparam int WORD_W  = 64;
  localparam int CHECK_W = 8;

  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_DATA = 2'd1,
    SLOT_CHK  = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic  holdLoad;
    logic  commit;
    logic  useGen;
    logic  rdEn;
    slot_e rdSel;
  } dp_cmd_t;

  function automatic logic [CHECK_W-1:0] byteParity(input logic [WORD_W-1:0] w);
    logic [CHECK_W-1:0] p;
    for (int i = 0; i < CHECK_W; i++) p[i] = ^w[8*i +: 8];
    return p;
  endfunction

endpackage

// File: rtl/arrport_ctrl.sv
module arrport_ctrl import arrport_pkg::*; #(
  parameter int AW       = 4,
  parameter int WRAP0    = 16,
  parameter int WRAP1    = 10,
  parameter int ADDR_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regEn,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [2:0]        flagIn,
  input  logic [AW-1:0]     addrIn,
  output dp_cmd_t           cmd,
  output logic [AW-1:0]     ptr,
  output logic              autoInc,
  output logic              eccGen,
  output logic              bankSel,
  output logic [WORD_W-1:0] ctrlView
);

  localparam logic [AW-1:0] LAST0 = AW'(WRAP0 - 1);
  localparam logic [AW-1:0] LAST1 = AW'(WRAP1 - 1);

  slot_e         sel;
  logic          ctrlWr;
  logic          chkAccess;
  logic [AW-1:0] lastEntry;
  logic [AW-1:0] loadPtr;

  assign sel       = slot_e'(regAddr);
  assign ctrlWr    = regEn && regWe && (sel == SLOT_CTRL);
  assign chkAccess = regEn && (sel == SLOT_CHK);
  assign lastEntry = bankSel ? LAST1 : LAST0;

  always_comb begin
    if (int'(addrIn) >= (flagIn[2] ? WRAP1 : WRAP0)) loadPtr = '0;
    else                                             loadPtr = addrIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      autoInc <= 1'b0;
      eccGen  <= 1'b0;
      bankSel <= 1'b0;
      ptr     <= '0;
    end else if (ctrlWr) begin
      autoInc <= flagIn[0];
      eccGen  <= flagIn[1];
      bankSel <= flagIn[2];
      ptr     <= loadPtr;
    end else if (chkAccess && autoInc) begin
      if (ptr == lastEntry) ptr <= '0;
      else                  ptr <= ptr + AW'(1);
    end
  end

  always_comb begin
    cmd.holdLoad = regEn && regWe && (sel == SLOT_DATA);
    cmd.commit   = regEn && regWe && (sel == SLOT_CHK);
    cmd.useGen   = eccGen;
    cmd.rdEn     = regEn && !regWe;
    cmd.rdSel    = sel;
  end

  always_comb begin
    ctrlView                  = '0;
    ctrlView[0]               = autoInc;
    ctrlView[1]               = eccGen;
    ctrlView[2]               = bankSel;
    ctrlView[ADDR_LSB +: AW]  = ptr;
  end

endmodule

// File: rtl/arrport_dp.sv
module arrport_dp import arrport_pkg::*; #(
  parameter int AW        = 4,
  parameter int DEPTH     = 16,
  parameter int NUM_BANKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_cmd_t           cmd,
  input  logic [AW-1:0]     ptr,
  input  logic              bankSel,
  input  logic [WORD_W-1:0] regWdata,
  input  logic [WORD_W-1:0] ctrlView,
  output logic [WORD_W-1:0] regRdata
);

  logic [WORD_W-1:0]  hold;
  logic [CHECK_W-1:0] chkIn;
  logic [WORD_W-1:0]  bankWord [NUM_BANKS];
  logic [CHECK_W-1:0] bankChk  [NUM_BANKS];

  assign chkIn = cmd.useGen ? byteParity(hold) : regWdata[CHECK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)             hold <= '0;
    else if (cmd.holdLoad) hold <= regWdata;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [WORD_W-1:0]  memD [DEPTH];
    logic [CHECK_W-1:0] memE [DEPTH];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) begin
          memD[i] <= '0;
          memE[i] <= '0;
        end
      end else if (cmd.commit && (int'(bankSel) == b)) begin
        memD[ptr] <= hold;
        memE[ptr] <= chkIn;
      end
    end

    assign bankWord[b] = memD[ptr];
    assign bankChk[b]  = memE[ptr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata <= '0;
    end else if (cmd.rdEn) begin
      case (cmd.rdSel)
        SLOT_CTRL: regRdata <= ctrlView;
        SLOT_DATA: regRdata <= bankWord[bankSel];
        SLOT_CHK:  regRdata <= {{(WORD_W-CHECK_W){1'b0}}, bankChk[bankSel]};
        default:   regRdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/arrport.sv
module arrport import arrport_pkg::*; #(
  parameter int DEPTH    = 16,
  parameter int WRAP0    = 16,
  parameter int WRAP1    = 10,
  parameter int ADDR_LSB = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regEn,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [63:0] regWdata,
  output logic [63:0] regRdata
);

  localparam int AW = $clog2(DEPTH);

  dp_cmd_t           cmd;
  logic [AW-1:0]     ptr;
  logic              autoInc;
  logic              eccGen;
  logic              bankSel;
  logic [WORD_W-1:0] ctrlView;

  arrport_ctrl #(
    .AW(AW), .WRAP0(WRAP0), .WRAP1(WRAP1), .ADDR_LSB(ADDR_LSB)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWe(regWe), .regAddr(regAddr),
    .flagIn(regWdata[2:0]), .addrIn(regWdata[ADDR_LSB +: AW]),
    .cmd(cmd), .ptr(ptr), .autoInc(autoInc), .eccGen(eccGen),
    .bankSel(bankSel), .ctrlView(ctrlView)
  );

  arrport_dp #(
    .AW(AW), .DEPTH(DEPTH), .NUM_BANKS(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ptr(ptr), .bankSel(bankSel),
    .regWdata(regWdata), .ctrlView(ctrlView), .regRdata(regRdata)
  );

endmodule

// File: rtl/arrport_chk.sv
module arrport_chk #(
  parameter int AW    = 4,
  parameter int WRAP0 = 16,
  parameter int WRAP1 = 10
) (
  input logic          clk,
  input logic          rstN,
  input logic          regEn,
  input logic          regWe,
  input logic [1:0]    regAddr,
  input logic [63:0]   regRdata,
  input logic [AW-1:0] ptr,
  input logic          autoInc,
  input logic          bankSel
);

  logic [AW-1:0] lastEntry;
  logic          chkAcc;
  assign lastEntry = bankSel ? AW'(WRAP1 - 1) : AW'(WRAP0 - 1);
  assign chkAcc    = regEn && (regAddr == 2'd2);

  // R7
  step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkAcc && autoInc && (ptr != lastEntry) |=> ptr == $past(ptr) + AW'(1));

  // R9
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkAcc && autoInc && (ptr == lastEntry) |=> ptr == '0);

  // R8
  ptr_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkAcc && !autoInc |=> $stable(ptr));

  // R6
  data_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    regEn && (regAddr == 2'd1) |=> $stable(ptr));

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= lastEntry);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regEn && !regWe) |=> $stable(regRdata));

  // R10
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regEn && !regWe && (regAddr == 2'd3) |=> regRdata == 64'd0);

endmodule

bind arrport arrport_chk #(.AW(AW), .WRAP0(WRAP0), .WRAP1(WRAP1)) u_chk (
  .clk(clk), .rstN(rstN), .regEn(regEn), .regWe(regWe), .regAddr(regAddr),
  .regRdata(regRdata), .ptr(ptr), .autoInc(autoInc), .bankSel(bankSel)
);

// File: tb/arrport_test.sv
module arrport_test;

  localparam int WRAP0 = 16;
  localparam int WRAP1 = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regEn = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  logic [63:0] mD [2][16];
  logic [7:0]  mE [2][16];
  logic [63:0] mHold;
  int          mPtr;
  bit          mAi, mGen, mBk;
  logic [63:0] lastRd;

  always #5 clk = ~clk;

  arrport uut (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  function automatic logic [7:0] par8(input logic [63:0] w);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ^w[8*i +: 8];
    return p;
  endfunction

  function automatic int wrapOf(input bit bk);
    return bk ? WRAP1 : WRAP0;
  endfunction

  function automatic void stepPtr();
    if (mAi) mPtr = (mPtr == wrapOf(mBk) - 1) ? 0 : mPtr + 1;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus(input bit we, input logic [1:0] a, input logic [63:0] wd);
    @(negedge clk);
    regEn = 1'b1; regWe = we; regAddr = a; regWdata = wd;
    @(negedge clk);
    regEn = 1'b0; regWe = 1'b0;
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [63:0] wd);
    bus(1'b1, a, wd);
    case (a)
      2'd0: begin
        mAi = wd[0]; mGen = wd[1]; mBk = wd[2];
        mPtr = (int'(wd[19:16]) >= wrapOf(mBk)) ? 0 : int'(wd[19:16]);
      end
      2'd1: mHold = wd;
      2'd2: begin
        mD[mBk][mPtr] = mHold;
        mE[mBk][mPtr] = mGen ? par8(mHold) : wd[7:0];
        stepPtr();
      end
      default: ;
    endcase
  endtask

  function automatic logic [63:0] ctrlExp();
    logic [63:0] v = '0;
    v[0] = mAi; v[1] = mGen; v[2] = mBk; v[19:16] = 4'(mPtr);
    return v;
  endfunction

  task automatic doRead(input logic [1:0] a, input string tag);
    logic [63:0] exp;
    case (a)
      2'd0: exp = ctrlExp();
      2'd1: exp = mD[mBk][mPtr];
      2'd2: exp = {56'd0, mE[mBk][mPtr]};
      default: exp = '0;
    endcase
    bus(1'b0, a, {$urandom, $urandom});
    check(tag, regRdata, exp);
    lastRd = exp;
    if (a == 2'd2) stepPtr();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 16; i++) begin mD[b][i] = '0; mE[b][i] = '0; end
    mHold = '0; mPtr = 0; mAi = 0; mGen = 0; mBk = 0; lastRd = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    doRead(2'd0, "R1 ctrl");
    doRead(2'd1, "R1 data");
    doRead(2'd2, "R1 chk");

    // R2 control fields and pointer load
    doWrite(2'd0, 64'h0000_0000_0005_0003);
    doRead(2'd0, "R2 ctrl readback");

    // R4 staging only, then commit; R5 generator ignores written value
    doWrite(2'd1, 64'h0000_0000_0000_0003);
    doRead(2'd1, "R4 staged not stored");
    doWrite(2'd2, 64'hFF);
    doRead(2'd0, "R7 advance on chk write");
    doWrite(2'd0, 64'h0000_0000_0005_0000);
    doRead(2'd1, "R4 committed word");
    doRead(2'd2, "R5 generated check byte");

    // R5 generator off stores written byte; R8 pointer fixed
    doWrite(2'd1, 64'hDEAD_BEEF_0BAD_F00D);
    doWrite(2'd2, 64'h1234_5A);
    doRead(2'd0, "R8 pointer fixed");
    doRead(2'd2, "R5 written check byte");
    doRead(2'd1, "R6 data read");
    doRead(2'd1, "R6 data read again");
    doRead(2'd0, "R6 no advance on data read");

    // R3 out-of-range address on bank 1
    doWrite(2'd0, 64'h0000_0000_000C_0005);
    doRead(2'd0, "R3 clamp to zero");

    // R9 wrap on bank 1 at 9 and bank 0 at 15
    doWrite(2'd0, 64'h0000_0000_0009_0005);
    doRead(2'd2, "R9 chk read at bank1 last");
    doRead(2'd0, "R9 bank1 wrapped");
    doWrite(2'd0, 64'h0000_0000_000F_0001);
    doWrite(2'd1, 64'h0F0F_0F0F_0F0F_0F0F);
    doWrite(2'd2, 64'h77);
    doRead(2'd0, "R9 bank0 wrapped");
    doWrite(2'd0, 64'h0000_0000_000F_0000);
    doRead(2'd1, "R9 bank0 last entry");

    // R10 hold and spare slot
    repeat (3) @(negedge clk);
    check("R10 read data holds", regRdata, lastRd);
    doWrite(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    doRead(2'd0, "R10 spare write no effect");
    doRead(2'd3, "R10 spare reads zero");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int kind = int'($urandom_range(0, 9));
      logic [63:0] w = {$urandom, $urandom};
      case (kind)
        0: doWrite(2'd0, w);
        1, 2: doWrite(2'd1, w);
        3, 4: doWrite(2'd2, w);
        5: doRead(2'd0, "R2 random ctrl");
        6: doRead(2'd1, "R6 random data");
        7, 8: doRead(2'd2, "R7 random chk");
        default: begin
          if (w[0]) doWrite(2'd3, w);
          else      doRead(2'd3, "R10 random spare");
        end
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule